// File: doc/BRIEF.md
# Transition-Detect Power-Down Controller

This controller manages standby for a small registered logic block. It samples the block's data inputs and its logic clock, `lclk`, on the system clock. Each of these signals passes through a minimum-width qualifier, so a change counts as a transition only after it has held its new level for `QUAL_N` consecutive samples. Every qualified transition reloads an idle timer from `idle_limit`. When the timer runs out with no transition, the controller enters standby. A qualified transition on any watched signal wakes it again. A dedicated active-high power-down pin can also force standby. While that pin is high it blocks every wake-up, and it has no logic function of its own.

While in standby, `din_held` keeps the data value from the last awake cycle, so the logic block sees frozen inputs. After any wake-up, the first qualified rising edge of `lclk` only completes the wake and does not enable the registers. Starting with the second edge, each qualified rising edge produces a one-cycle `reg_en` pulse that the surrounding registers use as their clock enable. All pins are plain level signals sampled every cycle. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `tdpd_ctrl`

## Requirements
- R1: A signal change that holds for QUAL_N consecutive samples is qualified at the QUAL_N-th sampling edge. With idle_limit = L ≥ 1 and no further qualified transition, standby goes high at the edge L+1 cycles after the last qualifying edge.
- R2: With idle_limit = 0, loaded at a qualified transition, the controller never enters standby on its own.
- R3: In standby with the power-down pin low, a qualified transition on any data bit or on lclk clears standby at the edge after the qualifying edge.
- R4: A change lasting fewer than QUAL_N samples has no effect: it does not wake the controller and does not update din_held.
- R5: After any wake-up, the first qualified lclk rising edge gives no reg_en pulse. Every later qualified rising edge does give one.
- R6: Outside standby, din_held takes the qualified data value one edge after the qualifying edge. In standby it does not change.
- R7: With HAS_PD_PIN = 1, pd_pin high at an edge puts the controller in standby after that edge. While pd_pin is high, transitions do not wake it. After pd_pin falls, the controller stays in standby until a qualified transition arrives. reg_en is low while pd_pin is high.
- R8: When a qualified transition coincides with the cycle in which the idle timer would expire, the transition wins: standby stays low and the full idle period restarts.
- R9: While reset is asserted and right after it, standby and reg_en are 0 and din_held is all zeros.
- R10: In the active state, reg_en is high for exactly one cycle, the cycle right after the qualifying edge of a rising lclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DATA_W | Data inputs of the logic block |
| lclk | input | 1 | Logic clock level, sampled as a watched signal |
| pd_pin | input | 1 | Dedicated power-down request, active high |
| idle_limit | input | IDLE_W | Idle period in clock cycles, taken at each qualified transition; 0 disables the timeout |
| din_held | output | DATA_W | Qualified data, frozen during standby |
| reg_en | output | 1 | One-cycle register enable per accepted lclk rising edge |
| standby | output | 1 | High while powered down |

## Verification
Two pairs of functions can land in the same cycle: a qualified transition against timer expiry, and a power-down request against a wake event. The bench times a second data change so that it qualifies exactly in the cycle where the counter sits at its last count. It then checks that standby stays low at the edge where it would have risen, and that it rises one full idle period later. A separate case drives data changes while pd_pin is high and checks that standby and din_held do not move, both while the pin is high and after it falls.

// File: rtl/tdpd_pkg.sv
`timescale 1ns/1ps
package tdpd_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_ARMING  = 2'd1,
    PS_STANDBY = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/tdpd_glitch_filt.sv
`timescale 1ns/1ps
// Minimum-width qualifier for one sampled signal.
module tdpd_glitch_filt #(
  parameter int QUAL_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic chg
);
  localparam int CW = $clog2(QUAL_N + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_N - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      chg <= 1'b0;
      run <= '0;
    end else begin
      chg <= 1'b0;
      if (raw == lvl) begin
        run <= '0;
      end else if (run == LAST) begin
        lvl <= raw;
        chg <= 1'b1;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdpd_idle_timer.sv
`timescale 1ns/1ps
// Counts down idle cycles; a value of zero while awake means "load".
module tdpd_idle_timer #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              evt,
  input  logic [IDLE_W-1:0] limit,
  output logic              expire
);
  logic [IDLE_W-1:0] cnt;

  assign expire = awake && !evt && (cnt == IDLE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (evt) begin
      cnt <= limit;
    end else if (!awake) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt <= limit;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tdpd_pwr_fsm.sv
`timescale 1ns/1ps
module tdpd_pwr_fsm
  import tdpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_force,
  input  logic       any_evt,
  input  logic       clk_rise,
  input  logic       expire,
  output pwr_state_e st
);
  pwr_state_e nxt;

  always_comb begin
    nxt = st;
    if (pd_force) begin
      nxt = PS_STANDBY;
    end else begin
      unique case (st)
        PS_ACTIVE:  if (expire) nxt = PS_STANDBY;
        PS_ARMING: begin
          if (expire)        nxt = PS_STANDBY;
          else if (clk_rise) nxt = PS_ACTIVE;
        end
        PS_STANDBY: begin
          // A clock rise wakes and is consumed; a data change arms.
          if (clk_rise)     nxt = PS_ACTIVE;
          else if (any_evt) nxt = PS_ARMING;
        end
        default: nxt = PS_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_ACTIVE;
    else        st <= nxt;
  end
endmodule

// File: rtl/tdpd_hold.sv
`timescale 1ns/1ps
module tdpd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/tdpd_ctrl.sv
`timescale 1ns/1ps
module tdpd_ctrl
  import tdpd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int QUAL_N     = 3,
  parameter int IDLE_W     = 16,
  parameter bit HAS_PD_PIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              lclk,
  input  logic              pd_pin,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic [DATA_W-1:0] din_held,
  output logic              reg_en,
  output logic              standby
);
  localparam int NSIG = DATA_W + 1;
  localparam int CKB  = DATA_W;

  logic [NSIG-1:0] raw_all;
  logic [NSIG-1:0] lvl_all;
  logic [NSIG-1:0] chg_all;
  logic            any_evt;
  logic            clk_rise;
  logic            pd_force;
  logic            expire;
  pwr_state_e      st;

  assign raw_all = {lclk, din};

  for (genvar g = 0; g < NSIG; g++) begin : g_qual
    tdpd_glitch_filt #(.QUAL_N(QUAL_N)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_all[g]),
      .lvl  (lvl_all[g]),
      .chg  (chg_all[g])
    );
  end

  if (HAS_PD_PIN) begin : g_pd
    assign pd_force = pd_pin;
  end else begin : g_nopd
    assign pd_force = 1'b0;
  end

  assign any_evt  = |chg_all;
  assign clk_rise = chg_all[CKB] & lvl_all[CKB];

  tdpd_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .awake (st != PS_STANDBY),
    .evt   (any_evt),
    .limit (idle_limit),
    .expire(expire)
  );

  tdpd_pwr_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_force(pd_force),
    .any_evt (any_evt),
    .clk_rise(clk_rise),
    .expire  (expire),
    .st      (st)
  );

  tdpd_hold #(.W(DATA_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (st != PS_STANDBY),
    .d    (lvl_all[DATA_W-1:0]),
    .q    (din_held)
  );

  assign reg_en  = clk_rise && (st == PS_ACTIVE) && !pd_force;
  assign standby = (st == PS_STANDBY);
endmodule

// File: rtl/tdpd_ctrl_chk.sv
`timescale 1ns/1ps
module tdpd_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_force,
  input logic              expire,
  input logic              standby,
  input logic              reg_en,
  input logic [DATA_W-1:0] din_held
);
  p_timeout_or_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> ($past(pd_force) || $past(expire)));

  p_wake_needs_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> !$past(pd_force));

  p_first_edge_swallowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !reg_en);

  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(din_held));

  p_pin_forces_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_force |=> standby);

  p_enable_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |=> !reg_en);
endmodule

bind tdpd_ctrl tdpd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pd_force(pd_force),
  .expire  (expire),
  .standby (standby),
  .reg_en  (reg_en),
  .din_held(din_held)
);

// File: tb/tdpd_ctrl_tb.sv
`timescale 1ns/1ps
module tdpd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        lclk = 1'b0;
  logic        pd_pin = 1'b0;
  logic [15:0] idle_limit = 16'd1000;
  logic [7:0]  din_held;
  logic        reg_en;
  logic        standby;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdpd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .lclk(lclk), .pd_pin(pd_pin),
    .idle_limit(idle_limit), .din_held(din_held), .reg_en(reg_en), .standby(standby)
  );

  // {value, cycles held, expected din_held afterwards}; QUAL_N is 3
  localparam logic [19:0] VEC [8] = '{
    {8'hA5, 4'd5, 8'hA5},
    {8'h5A, 4'd2, 8'hA5},
    {8'hA5, 4'd5, 8'hA5},
    {8'h3C, 4'd4, 8'h3C},
    {8'hC3, 4'd1, 8'h3C},
    {8'h3C, 4'd4, 8'h3C},
    {8'hFF, 4'd6, 8'hFF},
    {8'h00, 4'd4, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    nwait(2);
    chk("R9 standby in reset", 32'(standby), 0);
    chk("R9 reg_en in reset", 32'(reg_en), 0);
    rst_n = 1'b1;
    nwait(2);
    chk("R9 din_held after reset", 32'(din_held), 0);
    chk("R9 standby after reset", 32'(standby), 0);

    for (int i = 0; i < 8; i++) begin
      din = VEC[i][19:12];
      nwait(int'(VEC[i][11:8]));
      chk((VEC[i][11:8] < 4'd3) ? "R4 glitch ignored" : "R6 data tracked",
          32'(din_held), 32'(VEC[i][7:0]));
      chk("R1 awake during table", 32'(standby), 0);
    end

    // R1: exact idle timeout
    idle_limit = 16'd20;
    din = 8'h11;
    nwait(3);
    nwait(20);
    chk("R1 still awake at L", 32'(standby), 0);
    nwait(1);
    chk("R1 standby at L+1", 32'(standby), 1);

    // R7 and R6: pin holds standby, data frozen
    pd_pin = 1'b1;
    din = 8'h77;
    nwait(10);
    chk("R7 pin blocks wake", 32'(standby), 1);
    chk("R6 frozen under pin", 32'(din_held), 32'h11);
    pd_pin = 1'b0;
    nwait(10);
    chk("R7 waits for event", 32'(standby), 1);
    chk("R6 frozen after pin low", 32'(din_held), 32'h11);

    // R3 and R5: wake by clock rise, which is swallowed
    idle_limit = 16'd1000;
    lclk = 1'b1;
    nwait(3);
    chk("R5 wake edge no enable", 32'(reg_en), 0);
    nwait(1);
    chk("R3 woken by clock", 32'(standby), 0);
    nwait(1);
    chk("R6 tracks after wake", 32'(din_held), 32'h77);
    lclk = 1'b0;
    nwait(4);
    lclk = 1'b1;
    nwait(2);
    chk("R10 no early enable", 32'(reg_en), 0);
    nwait(1);
    chk("R5 second edge enables", 32'(reg_en), 1);
    nwait(1);
    chk("R10 single cycle", 32'(reg_en), 0);

    // R4 and R3: data wake, glitch ignored in standby
    lclk = 1'b0;
    nwait(4);
    idle_limit = 16'd20;
    din = 8'h22;
    nwait(28);
    chk("R1 standby again", 32'(standby), 1);
    din = 8'h23;
    nwait(2);
    din = 8'h22;
    nwait(10);
    chk("R4 glitch no wake", 32'(standby), 1);
    chk("R4 glitch no data", 32'(din_held), 32'h22);
    idle_limit = 16'd1000;
    din = 8'h44;
    nwait(3);
    chk("R3 still down at qualify", 32'(standby), 1);
    nwait(1);
    chk("R3 woken by data", 32'(standby), 0);
    lclk = 1'b1;
    nwait(3);
    chk("R5 first edge after data wake", 32'(reg_en), 0);
    lclk = 1'b0;
    nwait(4);
    lclk = 1'b1;
    nwait(3);
    chk("R5 next edge enables", 32'(reg_en), 1);

    // R8: transition in the expiry cycle
    idle_limit = 16'd10;
    din = 8'h55;
    nwait(10);
    din = 8'h66;
    nwait(3);
    nwait(1);
    chk("R8 reload beats expiry", 32'(standby), 0);
    nwait(9);
    chk("R8 awake through new period", 32'(standby), 0);
    nwait(1);
    chk("R8 standby after new period", 32'(standby), 1);

    // R2: zero limit disables timeout
    idle_limit = 16'd0;
    din = 8'h67;
    nwait(200);
    chk("R2 no timeout", 32'(standby), 0);

    // R7: pin forces standby from active
    pd_pin = 1'b1;
    nwait(1);
    chk("R7 forced standby", 32'(standby), 1);
    chk("R7 no enable under pin", 32'(reg_en), 0);
    pd_pin = 1'b0;
    nwait(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule